// File: doc/BRIEF.md
# Serial Divider-Word Loader

This block receives configuration words for a frequency synthesizer over three wires: a data line, a serial clock and a load-enable strobe. All three lines are asynchronous to the system clock. They are brought into the system clock domain, and every rising edge of the serial clock shifts one bit into a single shift register. The most significant bit is sent first, and the last bit sent is a routing flag.

When load-enable rises, the current register contents are copied into one of two holding registers. The routing flag picks which one. The reference holding register keeps a 14-bit reference divide ratio and three mode bits: prescaler select, phase-detector polarity and lock-output select. The divider holding register keeps a 7-bit swallow count and an 11-bit main count. Both register sets drive the divider and detector logic directly.

A ratio below the legal minimum of 5 is still stored, and a flag beside it is raised. The transfer is controlled by a three-state machine:
- `ST_HOLD` is the reset state. It waits for load-enable to be low and then takes the **arm** transition to `ST_ARMED`.
- `ST_ARMED` takes the **fire** transition to `ST_XFER` when load-enable is seen high.
- `ST_XFER` lasts one cycle. It issues the copy and then takes the **done** transition back to `ST_HOLD`.

Top module: `serload_port`

## Requirements
- R1: Each rising edge of `ser_clk` shifts exactly one bit of `ser_dat` into the register. Of all bits received, only the most recent 19 can affect a transfer.
- R2: At a transfer, the last bit received selects the destination. A value of 1 writes the reference register set, and a value of 0 writes the divider register set. The register set not selected keeps its value.
- R3: Divider word, counted back from the routing flag (the last bit received):
  - the 7 bits before the flag are the swallow count, with its LSB received just before the flag;
  - the 11 bits before those are the main count, with its LSB received latest.
- R4: Reference word, counted back from the routing flag:
  - the 14 bits before the flag are the reference ratio, with its LSB received just before the flag;
  - the bit before those is prescaler select;
  - the bit before that is phase polarity;
  - the bit before that is lock-output select.
- R5: Each low-to-high transition of `ser_le` causes exactly one transfer. Holding `ser_le` high causes no further transfer.
- R6: If `ser_le` rises before a system clock edge, the new fields appear at the outputs after the 4th rising edge of `clk`, counting that edge as the first.
- R7: A stored reference ratio below 5 is kept unchanged, and `ref_ratio_low` is 1 while it is held. Otherwise `ref_ratio_low` is 0.
- R8: A stored main count below 5 is kept unchanged, and `main_ratio_low` is 1 while it is held. Otherwise `main_ratio_low` is 0.
- R9: After reset, every field output and both flags are 0.
- R10: Bits shifted while `ser_le` is still high do not change the outputs. They are used by the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, shifts on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load enable; a rising edge commits the word |
| ref_ratio | output | 14 | Reference divide ratio |
| presc_sel | output | 1 | Prescaler modulus select |
| pd_polarity | output | 1 | Phase detector polarity |
| lock_out_sel | output | 1 | Lock/monitor output select |
| swallow_cnt | output | 7 | Swallow counter preset |
| main_cnt | output | 11 | Main counter preset |
| ref_ratio_low | output | 1 | Stored reference ratio is below 5 |
| main_ratio_low | output | 1 | Stored main count is below 5 |

## Verification
The loader is driven with the following words:
- Divider and reference words with asymmetric bit patterns. These expose a reversed or shifted field, since such a fault moves a value into a neighbouring field or into the other register set.
- Boundary ratios of 3, 4, 5 and all ones. These separate a wrong comparison bound from a correct one.
- A word preceded by extra leading bits. This shows that only the most recent bits count.
- A long load-enable pulse with a second word shifted during it. This tells a level-triggered transfer apart from an edge-triggered one.

A behavioural model in the bench compares every output on every clock. The exact cycle in which the fields change is therefore also checked.

// File: rtl/serload_pkg.sv
package serload_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_XFER  = 2'd2
    } load_state_t;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/serload_sync.sv
module serload_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/serload_shifter.sv
module serload_shifter #(
    parameter int WORD_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              dat_s,
    output logic [WORD_W-1:0] sr
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sr     <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (sclk_s && !sclk_q)
                sr <= {sr[WORD_W-2:0], dat_s};
        end
    end
endmodule

// File: rtl/serload_fsm.sv
module serload_fsm
    import serload_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le_s,
    input  logic route_bit,
    output logic ld_ref,
    output logic ld_div
);
    load_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD:  if (!le_s) state_nxt = ST_ARMED;
            ST_ARMED: if (le_s)  state_nxt = ST_XFER;
            ST_XFER:             state_nxt = ST_HOLD;
            default:             state_nxt = ST_HOLD;
        endcase
    end

    always_comb begin
        ld_ref = 1'b0;
        ld_div = 1'b0;
        unique case (state)
            ST_XFER: begin
                ld_ref = route_bit;
                ld_div = !route_bit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/serload_port.sv
module serload_port #(
    parameter int REF_W     = 14,
    parameter int SWAL_W    = 7,
    parameter int MAIN_W    = 11,
    parameter int MIN_RATIO = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_le,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              presc_sel,
    output logic              pd_polarity,
    output logic              lock_out_sel,
    output logic [SWAL_W-1:0] swallow_cnt,
    output logic [MAIN_W-1:0] main_cnt,
    output logic              ref_ratio_low,
    output logic              main_ratio_low
);
    localparam int REF_WORD = 1 + REF_W + 3;
    localparam int DIV_WORD = 1 + SWAL_W + MAIN_W;
    localparam int WORD_W   = (REF_WORD > DIV_WORD) ? REF_WORD : DIV_WORD;

    logic [2:0]        pins_s;
    logic [WORD_W-1:0] sr;
    logic              ld_ref, ld_div;
    logic              sclk_s, dat_s, le_s;

    serload_sync #(.WIDTH(3), .STAGES(serload_pkg::SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_le, ser_dat, ser_clk}),
        .sync_out (pins_s)
    );
    assign {le_s, dat_s, sclk_s} = pins_s;

    serload_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sclk_s),
        .dat_s  (dat_s),
        .sr     (sr)
    );

    serload_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .le_s      (le_s),
        .route_bit (sr[0]),
        .ld_ref    (ld_ref),
        .ld_div    (ld_div)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_ratio     <= '0;
            presc_sel     <= 1'b0;
            pd_polarity   <= 1'b0;
            lock_out_sel  <= 1'b0;
            ref_ratio_low <= 1'b0;
        end else if (ld_ref) begin
            ref_ratio     <= sr[REF_W:1];
            presc_sel     <= sr[REF_W+1];
            pd_polarity   <= sr[REF_W+2];
            lock_out_sel  <= sr[REF_W+3];
            ref_ratio_low <= (sr[REF_W:1] < REF_W'(MIN_RATIO));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swallow_cnt    <= '0;
            main_cnt       <= '0;
            main_ratio_low <= 1'b0;
        end else if (ld_div) begin
            swallow_cnt    <= sr[SWAL_W:1];
            main_cnt       <= sr[SWAL_W+MAIN_W:SWAL_W+1];
            main_ratio_low <= (sr[SWAL_W+MAIN_W:SWAL_W+1] < MAIN_W'(MIN_RATIO));
        end
    end
endmodule

// File: rtl/serload_checks.sv
module serload_checks #(
    parameter int REF_W     = 14,
    parameter int SWAL_W    = 7,
    parameter int MAIN_W    = 11,
    parameter int MIN_RATIO = 5,
    parameter int WORD_W    = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              le_s,
    input logic [WORD_W-1:0] sr,
    input logic              ld_ref,
    input logic              ld_div,
    input logic [REF_W-1:0]  ref_ratio,
    input logic              presc_sel,
    input logic              pd_polarity,
    input logic              lock_out_sel,
    input logic [SWAL_W-1:0] swallow_cnt,
    input logic [MAIN_W-1:0] main_cnt,
    input logic              ref_ratio_low,
    input logic              main_ratio_low
);
    a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_ref, ld_div}));

    a_r2_ref_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ref |=> $stable({ref_ratio, presc_sel, pd_polarity, lock_out_sel, ref_ratio_low}));

    a_r2_div_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_div |=> $stable({swallow_cnt, main_cnt, main_ratio_low}));

    a_r3_div_fields: assert property (@(posedge clk) disable iff (!rst_n)
        ld_div |=> (swallow_cnt == $past(sr[SWAL_W:1])) &&
                   (main_cnt == $past(sr[SWAL_W+MAIN_W:SWAL_W+1])));

    a_r4_ref_fields: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ref |=> (ref_ratio == $past(sr[REF_W:1])) && (lock_out_sel == $past(sr[REF_W+3])));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ref || ld_div) |=> !(ld_ref || ld_div));

    a_r5_needs_le: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ref || ld_div) |-> le_s);

    a_r7_ref_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ref |=> (ref_ratio_low == (ref_ratio < REF_W'(MIN_RATIO))));

    a_r8_main_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ld_div |=> (main_ratio_low == (main_cnt < MAIN_W'(MIN_RATIO))));
endmodule

bind serload_port serload_checks #(
    .REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W),
    .MIN_RATIO(MIN_RATIO), .WORD_W(WORD_W)
) i_checks (
    .clk(clk), .rst_n(rst_n), .le_s(le_s), .sr(sr),
    .ld_ref(ld_ref), .ld_div(ld_div),
    .ref_ratio(ref_ratio), .presc_sel(presc_sel), .pd_polarity(pd_polarity),
    .lock_out_sel(lock_out_sel), .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
    .ref_ratio_low(ref_ratio_low), .main_ratio_low(main_ratio_low)
);

// File: tb/test_serload_port.sv
module test_serload_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [13:0] ref_ratio;
    logic        presc_sel, pd_polarity, lock_out_sel;
    logic [6:0]  swallow_cnt;
    logic [10:0] main_cnt;
    logic        ref_ratio_low, main_ratio_low;

    int    n_chk = 0, n_fail = 0;
    bit    running = 0;
    string cur_tag = "R9";
    bit    bitq[$];

    int e_ref = 0, e_sw = 0, e_pol = 0, e_lock = 0, e_swal = 0, e_main = 0;
    int e_rlow = 0, e_mlow = 0;

    always #10 clk = ~clk;

    serload_port i_serload_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .presc_sel(presc_sel), .pd_polarity(pd_polarity),
        .lock_out_sel(lock_out_sel), .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
        .ref_ratio_low(ref_ratio_low), .main_ratio_low(main_ratio_low)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(ref_ratio == e_ref, "ref_ratio", ref_ratio, e_ref);
        chk({lock_out_sel, pd_polarity, presc_sel} == {e_lock[0], e_pol[0], e_sw[0]},
            "mode bits", {lock_out_sel, pd_polarity, presc_sel},
            {e_lock[0], e_pol[0], e_sw[0]});
        chk(swallow_cnt == e_swal, "swallow_cnt", swallow_cnt, e_swal);
        chk(main_cnt == e_main, "main_cnt", main_cnt, e_main);
        chk(ref_ratio_low == e_rlow[0], "ref_ratio_low", ref_ratio_low, e_rlow);
        chk(main_ratio_low == e_mlow[0], "main_ratio_low", main_ratio_low, e_mlow);
    endtask

    always @(negedge clk) if (running) compare_all();

    function automatic int getb(int back);
        int n = bitq.size();
        return (back < n) ? int'(bitq[n-1-back]) : 0;
    endfunction

    task automatic commit();
        if (getb(0) == 1) begin
            e_ref = 0;
            for (int k = 1; k <= 14; k++) e_ref |= getb(k) << (k-1);
            e_sw = getb(15); e_pol = getb(16); e_lock = getb(17);
            e_rlow = (e_ref < 5) ? 1 : 0;
        end else begin
            e_swal = 0; e_main = 0;
            for (int k = 1; k <= 7; k++)  e_swal |= getb(k) << (k-1);
            for (int k = 1; k <= 11; k++) e_main |= getb(7+k) << (k-1);
            e_mlow = (e_main < 5) ? 1 : 0;
        end
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk); ser_dat = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1; bitq.push_back(b);
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w, input int n);
        for (int i = n-1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic le_rise();
        @(negedge clk); ser_le = 1'b1;
        repeat (4) @(posedge clk);
        commit();
    endtask

    task automatic le_fall();
        @(negedge clk); ser_le = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic load_div(input int a, input int n);
        send_word({13'd0, n[10:0], a[6:0], 1'b0}, 19);
        le_rise(); repeat (2) @(negedge clk); le_fall();
    endtask

    task automatic load_ref(input int r, input bit sw, input bit fc, input bit lds);
        send_word({14'd0, lds, fc, sw, r[13:0], 1'b1}, 18);
        le_rise(); repeat (2) @(negedge clk); le_fall();
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_tag = "R9";
        compare_all();
        rst_n = 1'b1;
        running = 1;
        repeat (4) @(negedge clk);

        cur_tag = "R3"; load_div(5, 100);
        cur_tag = "R4"; load_ref(1000, 1'b1, 1'b0, 1'b1);
        cur_tag = "R2"; load_div(127, 1234);
        cur_tag = "R6"; load_ref(16383, 1'b0, 1'b1, 1'b0);
        cur_tag = "R7"; load_ref(3, 1'b1, 1'b1, 1'b1);
        cur_tag = "R7"; load_ref(5, 1'b0, 1'b0, 1'b1);
        cur_tag = "R8"; load_div(0, 4);
        cur_tag = "R8"; load_div(1, 5);
        cur_tag = "R8"; load_div(64, 2047);

        cur_tag = "R1";
        send_word(32'h00ABCDE, 25);
        load_div(3, 700);

        cur_tag = "R5";
        send_word({14'd0, 1'b1, 1'b0, 1'b1, 14'd777, 1'b1}, 18);
        le_rise();
        repeat (40) @(negedge clk);
        cur_tag = "R10";
        send_word({13'd0, 11'd333, 7'd9, 1'b0}, 19);
        repeat (20) @(negedge clk);
        le_fall();
        le_rise(); le_fall();

        repeat (5) @(negedge clk);
        running = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule